// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This unit decides where a 16-bit processor fetches next after a control-flow instruction. It takes the instruction word, the already incremented PC, the three sign flags (negative, zero, positive) and the value of the base register named by the instruction. It returns the following PC and a taken flag. For a trap call it also returns a request to write the return address into R7. Instructions that are not control flow fall through to the incremented PC.

Three forms are handled. A conditional branch tests a three-bit condition mask against the flags. A register jump loads the base value. A trap call reads a 16-bit service-routine address from a table of 256 words at the bottom of memory, indexed by an 8-bit vector. The table read goes over a simple read request / read-valid port, and the unit reports busy until the word returns. The halt vector additionally freezes the unit, so no further instruction is accepted.

Top module: `pc_next_unit`

## Requirements
- R1: An instruction is accepted when `instr_valid_i` is high while `busy_o` and `halt_o` are low. Branch is opcode 0000 in bits 15:12. Bits 11, 10 and 9 are the mask for negative, zero and positive, matching `flags_i[2]`, `[1]` and `[0]`. The branch is taken exactly when some mask bit and its flag are both set.
- R2: A taken branch yields `next_pc_o` equal to `pc_inc_i` plus bits 8:0 sign-extended, modulo 2^16. A branch that is not taken yields `pc_inc_i` with `taken_o` low.
- R3: A branch with mask 000 is never taken. A branch with mask 111 is taken whenever any flag is set.
- R4: Register jump is opcode 1100. It always yields `taken_o` high and `next_pc_o` equal to `base_i`.
- R5: Every opcode other than 0000, 1100 and 1111 yields `next_pc_o` equal to `pc_inc_i` with `taken_o` low.
- R6: For a branch, jump or other opcode, `pc_valid_o` is a single-cycle pulse. It appears in the cycle after acceptance, together with the result.
- R7: Trap is opcode 1111, with its vector in bits 7:0. In the cycle after acceptance, `mem_rd_o` pulses for one cycle with `mem_addr_o` equal to the vector zero-extended. In that same cycle `ret_we_o` pulses with `ret_data_o` equal to the accepted `pc_inc_i`, and `busy_o` goes high.
- R8: In the cycle after `mem_rvalid_i` is seen while busy, `pc_valid_o` pulses with `taken_o` high and `next_pc_o` equal to `mem_rdata_i`, and `busy_o` falls.
- R9: An `instr_valid_i` raised while busy is ignored: it produces no `pc_valid_o` and no `mem_rd_o`.
- R10: A trap with vector 0x25 sets `halt_o` in the cycle after acceptance, and `halt_o` stays high until reset. Every later instruction is ignored. Vectors 0x21, 0x23 and all others leave `halt_o` low.
- R11: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present |
| instr_i | input | 16 | Instruction word |
| pc_inc_i | input | 16 | Address of the following instruction |
| flags_i | input | 3 | Sign flags {negative, zero, positive} |
| base_i | input | 16 | Value of the base register selected by the jump |
| mem_rdata_i | input | 16 | Trap-table word returned |
| mem_rvalid_i | input | 1 | Trap-table word valid |
| pc_valid_o | output | 1 | Result pulse |
| next_pc_o | output | 16 | Next fetch address |
| taken_o | output | 1 | Control transfer taken |
| mem_rd_o | output | 1 | Trap-table read request |
| mem_addr_o | output | 16 | Trap-table address |
| ret_we_o | output | 1 | Return-address write to R7 |
| ret_data_o | output | 16 | Return address |
| busy_o | output | 1 | Waiting for the trap-table word |
| halt_o | output | 1 | Halted, no further acceptance |

## Verification
Branch, jump and fall-through results appear one register after the accepting edge. The trap read request and the return-address write also appear one register after acceptance. The trap redirect appears one register after the edge that samples `mem_rvalid_i`. The bench drives every input on the falling edge and samples on the next falling edge after the edge that should produce the result. Every cycle of a table-read wait, including wait lengths of zero to three cycles, is also sampled to confirm that no stray result or request appears.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_COND = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_JREG = 4'b1100;
  localparam logic [OPC_W-1:0] OPC_TRAP = 4'b1111;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } pcu_state_e;

  typedef struct packed {
    logic is_cond;
    logic is_jreg;
    logic is_trap;
  } pcu_kind_t;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int unsigned XLEN  = 16,
  parameter int unsigned OFF_W = 9,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned MSK_W = 3
) (
  input  logic [XLEN-1:0]  instr_i,
  output pcu_kind_t        kind_o,
  output logic [MSK_W-1:0] mask_o,
  output logic [OFF_W-1:0] off_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned OPC_LSB = XLEN - OPC_W;

  logic [OPC_W-1:0] opc;
  assign opc = instr_i[XLEN-1:OPC_LSB];

  always_comb begin
    kind_o.is_cond = (opc == OPC_COND);
    kind_o.is_jreg = (opc == OPC_JREG);
    kind_o.is_trap = (opc == OPC_TRAP);
  end

  assign mask_o = instr_i[OFF_W+MSK_W-1:OFF_W];
  assign off_o  = instr_i[OFF_W-1:0];
  assign vec_o  = instr_i[VEC_W-1:0];
endmodule

// File: rtl/pcu_cond.sv
module pcu_cond #(
  parameter int unsigned MSK_W = 3
) (
  input  logic [MSK_W-1:0] mask_i,
  input  logic [MSK_W-1:0] flags_i,
  output logic             take_o
);
  logic [MSK_W-1:0] hit;

  for (genvar g = 0; g < MSK_W; g++) begin : g_hit
    assign hit[g] = mask_i[g] & flags_i[g];
  end

  assign take_o = |hit;
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int unsigned XLEN  = 16,
  parameter int unsigned OFF_W = 9
) (
  input  logic [XLEN-1:0]  pc_inc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int unsigned EXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_sx;
  assign off_sx   = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign target_o = pc_inc_i + off_sx;
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int unsigned XLEN     = 16,
  parameter int unsigned OFF_W    = 9,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned MSK_W    = 3,
  parameter logic [7:0]  HALT_VEC = 8'h25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  pc_inc_i,
  input  logic [MSK_W-1:0] flags_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_rvalid_i,
  output logic             pc_valid_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o,
  output logic             mem_rd_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic             ret_we_o,
  output logic [XLEN-1:0]  ret_data_o,
  output logic             busy_o,
  output logic             halt_o
);
  localparam int unsigned PAD_W = XLEN - VEC_W;

  pcu_kind_t        kind;
  logic [MSK_W-1:0] mask;
  logic [OFF_W-1:0] off;
  logic [VEC_W-1:0] vec;
  logic             take;
  logic [XLEN-1:0]  target;

  pcu_decode #(.XLEN(XLEN), .OFF_W(OFF_W), .VEC_W(VEC_W), .MSK_W(MSK_W)) u_dec (
    .instr_i(instr_i),
    .kind_o (kind),
    .mask_o (mask),
    .off_o  (off),
    .vec_o  (vec)
  );

  pcu_cond #(.MSK_W(MSK_W)) u_cond (
    .mask_i (mask),
    .flags_i(flags_i),
    .take_o (take)
  );

  pcu_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc_inc_i(pc_inc_i),
    .off_i   (off),
    .target_o(target)
  );

  pcu_state_e      state_q;
  logic            pc_valid_q, taken_q, mem_rd_q, ret_we_q, halt_q;
  logic [XLEN-1:0] next_pc_q, mem_addr_q, ret_data_q;
  logic            accept, br_take;
  logic [XLEN-1:0] seq_pc;

  assign accept  = instr_valid_i && (state_q == ST_IDLE) && !halt_q;
  assign br_take = kind.is_cond && take;

  always_comb begin
    if (kind.is_jreg)  seq_pc = base_i;
    else if (br_take)  seq_pc = target;
    else               seq_pc = pc_inc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pc_valid_q <= 1'b0;
      taken_q    <= 1'b0;
      mem_rd_q   <= 1'b0;
      ret_we_q   <= 1'b0;
      halt_q     <= 1'b0;
      next_pc_q  <= '0;
      mem_addr_q <= '0;
      ret_data_q <= '0;
    end else begin
      pc_valid_q <= 1'b0;
      mem_rd_q   <= 1'b0;
      ret_we_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (kind.is_trap) begin
              mem_rd_q   <= 1'b1;
              mem_addr_q <= {{PAD_W{1'b0}}, vec};
              ret_we_q   <= 1'b1;
              ret_data_q <= pc_inc_i;
              state_q    <= ST_WAIT;
              if (vec == HALT_VEC[VEC_W-1:0]) halt_q <= 1'b1;
            end else begin
              pc_valid_q <= 1'b1;
              next_pc_q  <= seq_pc;
              taken_q    <= kind.is_jreg | br_take;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            pc_valid_q <= 1'b1;
            next_pc_q  <= mem_rdata_i;
            taken_q    <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pc_valid_o = pc_valid_q;
  assign next_pc_o  = next_pc_q;
  assign taken_o    = taken_q;
  assign mem_rd_o   = mem_rd_q;
  assign mem_addr_o = mem_addr_q;
  assign ret_we_o   = ret_we_q;
  assign ret_data_o = ret_data_q;
  assign busy_o     = (state_q == ST_WAIT);
  assign halt_o     = halt_q;
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int unsigned XLEN  = 16,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned MSK_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_valid_i,
  input logic [XLEN-1:0]  instr_i,
  input logic [XLEN-1:0]  pc_inc_i,
  input logic [MSK_W-1:0] flags_i,
  input logic [XLEN-1:0]  base_i,
  input logic [XLEN-1:0]  mem_rdata_i,
  input logic             mem_rvalid_i,
  input logic             pc_valid_o,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             taken_o,
  input logic             mem_rd_o,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic             ret_we_o,
  input logic [XLEN-1:0]  ret_data_o,
  input logic             busy_o,
  input logic             halt_o
);
  logic acc;
  assign acc = instr_valid_i && !busy_o && !halt_o;

  // R1
  br_hit_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && instr_i[15:12] == 4'b0000 && (instr_i[11:9] & flags_i) != 3'b000 |=> pc_valid_o && taken_o);

  // R3
  br_nomask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && instr_i[15:12] == 4'b0000 && instr_i[11:9] == 3'b000 |=> pc_valid_o && !taken_o);

  // R4
  jreg_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && instr_i[15:12] == 4'b1100 |=> pc_valid_o && taken_o && next_pc_o == $past(base_i));

  // R7
  trap_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && instr_i[15:12] == 4'b1111 |=> mem_rd_o && ret_we_o && busy_o && ret_data_o == $past(pc_inc_i)
      && mem_addr_o == {{(XLEN-VEC_W){1'b0}}, $past(instr_i[VEC_W-1:0])});

  // R7
  trap_rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  // R8
  trap_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mem_rvalid_i |=> pc_valid_o && taken_o && !busy_o && next_pc_o == $past(mem_rdata_i));

  // R9
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_rvalid_i |=> !pc_valid_o && !mem_rd_o);

  // R10
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  // R10
  halt_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && $past(halt_o) |-> !mem_rd_o);
endmodule

bind pc_next_unit pcu_chk #(.XLEN(XLEN), .VEC_W(VEC_W), .MSK_W(MSK_W)) u_chk (.*);

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] pc_inc_i = '0;
  logic [2:0]  flags_i = '0;
  logic [15:0] base_i = '0;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        pc_valid_o, taken_o, mem_rd_o, ret_we_o, busy_o, halt_o;
  logic [15:0] next_pc_o, mem_addr_o, ret_data_o;

  int n_run = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  pc_next_unit u0 (
    .clk_i, .rst_ni, .instr_valid_i, .instr_i, .pc_inc_i, .flags_i, .base_i,
    .mem_rdata_i, .mem_rvalid_i, .pc_valid_o, .next_pc_o, .taken_o, .mem_rd_o,
    .mem_addr_o, .ret_we_o, .ret_data_o, .busy_o, .halt_o
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive on a falling edge, return on the falling edge after the accepting edge
  task automatic issue(input logic [15:0] ins, input logic [15:0] pc, input logic [2:0] fl, input logic [15:0] bs);
    @(negedge clk_i);
    instr_i = ins; pc_inc_i = pc; flags_i = fl; base_i = bs; instr_valid_i = 1'b1;
    @(negedge clk_i);
    instr_valid_i = 1'b0;
  endtask

  task automatic trap_run(input logic [7:0] vec, input int lat, input logic [15:0] word);
    logic [15:0] pc;
    pc = 16'h3000 + {8'h00, vec};
    issue({4'b1111, 4'b0000, vec}, pc, 3'b010, 16'h0);
    chk(mem_rd_o == 1'b1, "R7 rd", {15'd0, mem_rd_o}, 16'd1);
    chk(mem_addr_o == {8'h00, vec}, "R7 addr", mem_addr_o, {8'h00, vec});
    chk(ret_we_o && ret_data_o == pc, "R7 ret", ret_data_o, pc);
    chk(busy_o && !pc_valid_o, "R7 busy", {14'd0, busy_o, pc_valid_o}, 16'd2);
    chk(halt_o == (vec == 8'h25), "R10 halt", {15'd0, halt_o}, {15'd0, vec == 8'h25});
    for (int l = 0; l < lat; l++) begin
      if (l == 0) begin
        instr_i = {4'b1100, 3'b000, 3'd2, 6'd0}; base_i = 16'hBEEF; instr_valid_i = 1'b1;
      end
      @(negedge clk_i);
      instr_valid_i = 1'b0;
      chk(!pc_valid_o && !mem_rd_o && busy_o, "R9 ignore", {14'd0, pc_valid_o, mem_rd_o}, 16'd0);
    end
    mem_rdata_i = word; mem_rvalid_i = 1'b1;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    chk(pc_valid_o && taken_o, "R8 valid", {14'd0, pc_valid_o, taken_o}, 16'd3);
    chk(next_pc_o == word, "R8 pc", next_pc_o, word);
    chk(!busy_o, "R8 busy", {15'd0, busy_o}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11
    chk(!pc_valid_o && !taken_o && !mem_rd_o && !ret_we_o && !busy_o && !halt_o,
        "R11 ctl", {10'd0, pc_valid_o, taken_o, mem_rd_o, ret_we_o, busy_o, halt_o}, 16'd0);
    chk(next_pc_o == 0 && mem_addr_o == 0 && ret_data_o == 0, "R11 data", next_pc_o | mem_addr_o | ret_data_o, 16'd0);
    rst_ni = 1'b1;

    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 8; f++) begin
        for (int o = 0; o < 5; o++) begin
          for (int p = 0; p < 3; p++) begin
            logic [8:0]  off;
            logic [15:0] pc, exp_pc;
            logic        exp_t;
            off = (o == 0) ? 9'd0 : (o == 1) ? 9'd1 : (o == 2) ? 9'd255 : (o == 3) ? 9'd256 : 9'd511;
            pc = (p == 0) ? 16'h3001 : (p == 1) ? 16'hFFFF : 16'h0000;
            exp_t = ((m[2:0] & f[2:0]) != 3'b000);
            exp_pc = exp_t ? pc + {{7{off[8]}}, off} : pc;
            issue({4'b0000, m[2:0], off}, pc, f[2:0], 16'h1234);
            chk(pc_valid_o, "R6 valid", {15'd0, pc_valid_o}, 16'd1);
            chk(taken_o == exp_t, "R1 taken", {15'd0, taken_o}, {15'd0, exp_t});
            chk(next_pc_o == exp_pc, "R2 target", next_pc_o, exp_pc);
            if (m == 0) chk(!taken_o, "R3 none", {15'd0, taken_o}, 16'd0);
            if (m == 7 && f != 0) chk(taken_o, "R3 all", {15'd0, taken_o}, 16'd1);
            @(negedge clk_i);
            chk(!pc_valid_o, "R6 pulse", {15'd0, pc_valid_o}, 16'd0);
          end
        end
      end
    end

    for (int i = 0; i < 8; i++) begin
      logic [15:0] bs;
      bs = 16'hF00D ^ (16'h1111 * i[15:0]);
      issue({4'b1100, 3'b000, i[2:0], 6'd0}, 16'h4000, 3'b000, bs);
      chk(pc_valid_o && taken_o, "R4 taken", {14'd0, pc_valid_o, taken_o}, 16'd3);
      chk(next_pc_o == bs, "R4 base", next_pc_o, bs);
    end

    for (int op = 1; op < 15; op++) begin
      if (op != 12) begin
        logic [15:0] pc;
        pc = 16'h2000 + op[15:0];
        issue({op[3:0], 12'hFFF}, pc, 3'b111, 16'hAAAA);
        chk(pc_valid_o && !taken_o, "R5 flag", {14'd0, pc_valid_o, taken_o}, 16'd2);
        chk(next_pc_o == pc, "R5 seq", next_pc_o, pc);
      end
    end

    for (int v = 0; v < 256; v++) begin
      if (v != 8'h25) trap_run(v[7:0], v % 4, (16'h0101 * v[15:0]) ^ 16'h5A5A);
    end

    trap_run(8'h25, 2, 16'h0520);
    issue({4'b1100, 3'b000, 3'd1, 6'd0}, 16'h1000, 3'b000, 16'h7777);
    chk(!pc_valid_o && !mem_rd_o, "R10 frozen", {14'd0, pc_valid_o, mem_rd_o}, 16'd0);
    issue({4'b1111, 4'b0000, 8'h21}, 16'h1001, 3'b000, 16'h0);
    chk(!mem_rd_o && !busy_o && halt_o, "R10 trap ignored", {13'd0, mem_rd_o, busy_o, halt_o}, 16'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'd0, 16'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule